// File: doc/BRIEF.md
# Request/Reply Message Input Buffer

This block is the receive stage of a node's network interface. Every arriving network transaction is sorted by kind into one of two separate queues: a request queue that feeds the node's request service logic, and a reply queue that feeds the logic waiting on answers to requests this node sent out. Because the two stores are independent, a backlog of requests can never stop a reply from being taken off the network. That is the condition needed to avoid fetch deadlock when the node's own outgoing path is stalled.

Request storage is split among the source nodes by credits. Each remote source may hold at most `OUTSTANDING` entries in the request queue, and the queue holds `OUTSTANDING*(NODES-1)` entries, so an admitted request always finds a slot. A request whose source has used up its credits is not stored. The block consumes it from the network and raises a negative acknowledgement addressed to that source. The acknowledgement sits in a one-entry holding register until the outgoing port takes it. The reply queue holds `OUTSTANDING` entries, one for each request this node may have in flight.

Top module: `msg_inbuf`

## Requirements
- R1: After reset both queues are empty (`req_valid_o` and `rep_valid_o` low), no negative acknowledgement is pending (`nack_valid_o` low), and an offered reply sees `in_ready_o` high.
- R2: An incoming message with `in_kind_i` = 1 is a reply. It is accepted whenever the reply queue holds fewer than `OUTSTANDING` entries, whatever the state of the request queue or the acknowledgement register. When the queue is full, `in_ready_o` is low for it.
- R3: An incoming message with `in_kind_i` = 0 is a request. If its source holds fewer than `OUTSTANDING` queued requests, the request is accepted and stored. Requests leave in arrival order across all sources, each carrying its source ID and data.
- R4: A request whose source already holds `OUTSTANDING` queued requests is accepted from the network but not stored. In the next cycle `nack_valid_o` is high and `nack_dst_o` equals that source.
- R5: A source's credit is returned when one of its requests is dequeued (`req_valid_o` and `req_ready_i` high), after which a further request from that source is stored.
- R6: While an acknowledgement is held and `nack_ready_i` is low, a request that would need an acknowledgement sees `in_ready_o` low. Requests with credit and replies are still accepted.
- R7: A held acknowledgement keeps `nack_valid_o` high and `nack_dst_o` unchanged until `nack_ready_i` is high. It is cleared in the cycle after that.
- R8: A request carrying the node's own ID (`NODE_ID`) as its source has no credits and is always refused with an acknowledgement.
- R9: The request queue never overflows, because its depth is `OUTSTANDING*(NODES-1)`.
- R10: The reply dequeue port works independently of the request dequeue port. Replies drain while the request queue is full and not being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming message valid |
| in_ready_o | output | 1 | Incoming message accepted this cycle |
| in_kind_i | input | 1 | Message kind: 0 request, 1 reply |
| in_src_i | input | $clog2(NODES) | Source node ID |
| in_data_i | input | DATA_W | Message data |
| nack_valid_o | output | 1 | Negative acknowledgement pending |
| nack_ready_i | input | 1 | Outgoing port takes the acknowledgement |
| nack_dst_o | output | $clog2(NODES) | Destination of the acknowledgement |
| req_valid_o | output | 1 | Request queue head valid |
| req_ready_i | input | 1 | Request consumer takes the head |
| req_src_o | output | $clog2(NODES) | Source of the head request |
| req_data_o | output | DATA_W | Data of the head request |
| rep_valid_o | output | 1 | Reply queue head valid |
| rep_ready_i | input | 1 | Reply consumer takes the head |
| rep_src_o | output | $clog2(NODES) | Source of the head reply |
| rep_data_o | output | DATA_W | Data of the head reply |

## Verification
The hardest state to reach is a stalled acknowledgement register combined with a full request queue. In that state the input must refuse only requests that need an acknowledgement, and it must keep taking replies and requests that still hold credit. The bench first sweeps every source ID, including the node's own, with one request more than the credit limit, which fills the request queue completely. It then holds `nack_ready_i` low, forces one more refusal, frees a single credit by dequeuing one request, and offers each message class against this mixed state.

// File: rtl/msg_inbuf_pkg.sv
package msg_inbuf_pkg;
  typedef enum logic {
    MSG_REQ = 1'b0,
    MSG_REP = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == FULL);
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  // R9: a full queue is never written
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R3: the head is only taken when present
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o);
endmodule

// File: rtl/credit_bank.sv
module credit_bank #(
  parameter int NODES   = 4,
  parameter int LIMIT   = 2,
  parameter int NODE_ID = 0,
  localparam int SRC_W  = $clog2(NODES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] query_src_i,
  output logic             avail_o,
  input  logic             take_i,
  input  logic [SRC_W-1:0] take_src_i,
  input  logic             give_i,
  input  logic [SRC_W-1:0] give_src_i
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] MAXC = CW'(LIMIT);

  logic [NODES-1:0] avail_vec;

  for (genvar s = 0; s < NODES; s++) begin : g_src
    if (s == NODE_ID) begin : g_self
      assign avail_vec[s] = 1'b0;  // own ID never earns slots
    end else begin : g_remote
      logic [CW-1:0] used_q;
      logic inc, dec;
      assign inc = take_i && (take_src_i == SRC_W'(s));
      assign dec = give_i && (give_src_i == SRC_W'(s));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) used_q <= '0;
        else         used_q <= used_q + CW'(inc) - CW'(dec);
      end
      assign avail_vec[s] = (used_q != MAXC);

      // R5: credit count stays within the per-source limit
      a_r5_credit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        used_q <= MAXC);
      // R5: a returned credit always belongs to a queued request
      a_r5_no_underrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec |-> (used_q != '0));
    end
  end

  assign avail_o = avail_vec[query_src_i];
endmodule

// File: rtl/nack_slot.sv
module nack_slot #(
  parameter int SRC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SRC_W-1:0] dst_i,
  output logic             free_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [SRC_W-1:0] dst_o
);
  logic             valid_q;
  logic [SRC_W-1:0] dst_q;

  assign free_o  = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign dst_o   = dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dst_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      dst_q   <= dst_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  // R6: a waiting acknowledgement is never overwritten
  a_r6_load_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!valid_o || ready_i));
  // R7: held until taken
  a_r7_nack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(dst_o)));
endmodule

// File: rtl/msg_inbuf.sv
module msg_inbuf
  import msg_inbuf_pkg::*;
#(
  parameter int NODES       = 4,
  parameter int OUTSTANDING = 2,
  parameter int NODE_ID     = 0,
  parameter int DATA_W      = 8,
  localparam int SRC_W      = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_kind_i,
  input  logic [SRC_W-1:0]  in_src_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              nack_valid_o,
  input  logic              nack_ready_i,
  output logic [SRC_W-1:0]  nack_dst_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [SRC_W-1:0]  req_src_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              rep_valid_o,
  input  logic              rep_ready_i,
  output logic [SRC_W-1:0]  rep_src_o,
  output logic [DATA_W-1:0] rep_data_o
);
  localparam int REQ_DEPTH = OUTSTANDING * (NODES - 1);
  localparam int REP_DEPTH = OUTSTANDING;
  localparam int ENT_W     = SRC_W + DATA_W;

  logic is_rep, credit_ok, nack_free, rep_full, req_full;
  logic fire, req_push, rep_push, nack_load, req_pop, rep_pop;

  assign is_rep = (msg_kind_e'(in_kind_i) == MSG_REP);

  // replies need only room; requests need a credit or a free NACK slot
  always_comb begin
    if (is_rep) in_ready_o = !rep_full;
    else        in_ready_o = credit_ok || nack_free;
  end

  assign fire      = in_valid_i && in_ready_o;
  assign rep_push  = fire && is_rep;
  assign req_push  = fire && !is_rep && credit_ok;
  assign nack_load = fire && !is_rep && !credit_ok;
  assign req_pop   = req_valid_o && req_ready_i;
  assign rep_pop   = rep_valid_o && rep_ready_i;

  credit_bank #(.NODES(NODES), .LIMIT(OUTSTANDING), .NODE_ID(NODE_ID)) i_credit (
    .clk_i, .rst_ni,
    .query_src_i (in_src_i),
    .avail_o     (credit_ok),
    .take_i      (req_push),
    .take_src_i  (in_src_i),
    .give_i      (req_pop),
    .give_src_i  (req_src_o)
  );

  msg_fifo #(.DEPTH(REQ_DEPTH), .WIDTH(ENT_W)) i_req_q (
    .clk_i, .rst_ni,
    .push_i  (req_push),
    .data_i  ({in_src_i, in_data_i}),
    .full_o  (req_full),
    .pop_i   (req_pop),
    .valid_o (req_valid_o),
    .data_o  ({req_src_o, req_data_o})
  );

  msg_fifo #(.DEPTH(REP_DEPTH), .WIDTH(ENT_W)) i_rep_q (
    .clk_i, .rst_ni,
    .push_i  (rep_push),
    .data_i  ({in_src_i, in_data_i}),
    .full_o  (rep_full),
    .pop_i   (rep_pop),
    .valid_o (rep_valid_o),
    .data_o  ({rep_src_o, rep_data_o})
  );

  nack_slot #(.SRC_W(SRC_W)) i_nack (
    .clk_i, .rst_ni,
    .load_i  (nack_load),
    .dst_i   (in_src_i),
    .free_o  (nack_free),
    .valid_o (nack_valid_o),
    .ready_i (nack_ready_i),
    .dst_o   (nack_dst_o)
  );

  // R9: credit admission alone keeps the request queue from filling past depth
  a_r9_credit_implies_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_ok |-> !req_full);
  // R4: refused request produces an acknowledgement to its source
  a_r4_nack_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !is_rep && !credit_ok) |=> (nack_valid_o && nack_dst_o == $past(in_src_i)));
  // R8: own ID is always refused
  a_r8_self_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !is_rep && in_src_i == SRC_W'(NODE_ID)) |=> nack_valid_o);
  // R2: an empty reply queue always takes a reply
  a_r2_reply_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_rep && !rep_valid_o) |-> in_ready_o);
endmodule

// File: tb/test_msg_inbuf.sv
module test_msg_inbuf;
  localparam int P = 4;
  localparam int K = 2;
  localparam int ME = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_kind = 1'b0;
  logic [1:0] in_src = '0;
  logic [7:0] in_data = '0;
  logic nack_ready = 1'b1, req_ready = 1'b0, rep_ready = 1'b0;
  logic in_ready, nack_valid, req_valid, rep_valid;
  logic [1:0] nack_dst, req_src, rep_src;
  logic [7:0] req_data, rep_data;

  int checks = 0, failures = 0;
  int used [P];
  int reqq [$];
  int repq [$];
  logic nack_pend = 1'b0;
  int nack_last = 0;

  always #2.5 clk = ~clk;

  msg_inbuf #(.NODES(P), .OUTSTANDING(K), .NODE_ID(ME), .DATA_W(8)) i_msg_inbuf (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_kind_i(in_kind),
    .in_src_i(in_src), .in_data_i(in_data),
    .nack_valid_o(nack_valid), .nack_ready_i(nack_ready), .nack_dst_o(nack_dst),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_src_o(req_src), .req_data_o(req_data),
    .rep_valid_o(rep_valid), .rep_ready_i(rep_ready), .rep_src_o(rep_src), .rep_data_o(rep_data)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // offer one message; starts and ends just after a falling edge
  task automatic offer(input logic rep, input int src, input int data, input string tag);
    logic exp_nack, exp_ready;
    exp_nack  = !rep && (src == ME || used[src] >= K);
    exp_ready = rep ? (repq.size() < K) : (!exp_nack || !nack_pend);
    in_valid = 1'b1; in_kind = rep; in_src = 2'(src); in_data = 8'(data);
    #1;
    check(in_ready == exp_ready, {tag, " ready"}, int'(in_ready), int'(exp_ready));
    if (in_ready) begin
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (rep) repq.push_back(src * 256 + data);
      else if (!exp_nack) begin
        reqq.push_back(src * 256 + data);
        used[src]++;
      end else begin
        nack_pend = !nack_ready;
        nack_last = src;
        check(nack_valid == 1'b1, {tag, " R4 nack valid"}, int'(nack_valid), 1);
        check(int'(nack_dst) == src, {tag, " R4 nack dst"}, int'(nack_dst), src);
      end
      if (!rep && !exp_nack) begin
        check(nack_valid == nack_pend, {tag, " R4 no nack"}, int'(nack_valid), int'(nack_pend));
      end
    end else begin
      in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pop_req(input string tag);
    int e;
    e = reqq.pop_front();
    check(req_valid == 1'b1, {tag, " R3 req valid"}, int'(req_valid), 1);
    check(int'({req_src, req_data}) == e, {tag, " R3 req entry"}, int'({req_src, req_data}), e);
    req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_ready = 1'b0;
    used[e / 256]--;
  endtask

  task automatic pop_rep(input string tag);
    int e;
    e = repq.pop_front();
    check(rep_valid == 1'b1, {tag, " R10 rep valid"}, int'(rep_valid), 1);
    check(int'({rep_src, rep_data}) == e, {tag, " R2 rep entry"}, int'({rep_src, rep_data}), e);
    rep_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rep_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < P; s++) used[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_valid == 1'b0, "R1 req empty", int'(req_valid), 0);
    check(rep_valid == 1'b0, "R1 rep empty", int'(rep_valid), 0);
    check(nack_valid == 1'b0, "R1 nack idle", int'(nack_valid), 0);
    in_kind = 1'b1; #1;
    check(in_ready == 1'b1, "R1 reply ready", int'(in_ready), 1);
    @(negedge clk);

    // sweep every source with K+1 requests (R3, R4, R8)
    for (int s = 0; s < P; s++)
      for (int n = 0; n <= K; n++)
        offer(1'b0, s, s * 16 + n, (s == ME) ? "R8 self" : "R3/R4 sweep");
    @(negedge clk);
    check(nack_valid == 1'b0, "R7 nack drained", int'(nack_valid), 0);

    // R2/R10: replies while request queue full and idle
    offer(1'b1, 1, 8'hA0, "R2 reply0");
    offer(1'b1, 2, 8'hA1, "R2 reply1");
    offer(1'b1, 3, 8'hA2, "R2 reply full");
    pop_rep("R10 drain0");
    check(req_valid == 1'b1, "R10 req still held", int'(req_valid), 1);
    pop_rep("R10 drain1");

    // R6/R7: stalled acknowledgement
    nack_ready = 1'b0;
    offer(1'b0, 1, 8'h55, "R6 first refusal");
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(nack_valid == 1'b1, "R7 nack held", int'(nack_valid), 1);
      check(int'(nack_dst) == 1, "R7 dst stable", int'(nack_dst), 1);
    end
    offer(1'b0, 2, 8'h66, "R6 second refusal stalls");
    offer(1'b0, ME, 8'h67, "R6 self stalls");
    offer(1'b1, 3, 8'hB0, "R6 reply still taken");
    pop_req("R5 free one");
    offer(1'b0, 1, 8'h77, "R5/R6 credit request taken");
    check(int'(nack_dst) == 1, "R7 dst kept", int'(nack_dst), 1);
    nack_ready = 1'b1;
    nack_pend = 1'b0;
    @(negedge clk);
    check(nack_valid == 1'b0, "R7 nack released", int'(nack_valid), 0);
    pop_rep("R10 drain2");

    // R3: drain in arrival order
    while (reqq.size() > 0) pop_req("R3 drain");
    check(req_valid == 1'b0, "R3 req empty", int'(req_valid), 0);

    // R5: repeated fill and release per source
    for (int s = 1; s < P; s++) begin
      for (int r = 0; r < 3; r++) begin
        offer(1'b0, s, 8'h80 + r, "R5 fill");
        offer(1'b0, s, 8'h90 + r, "R5 fill");
        offer(1'b0, s, 8'hC0 + r, "R5 over limit");
        pop_req("R5 release");
        pop_req("R5 release");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule